// File: doc/BRIEF.md
# Superpriority interrupt masking unit

This unit decides, once per clock, whether any pending physical or virtual interrupt request is to be delivered to a processing element, and which one. Besides the ordinary IRQ and FIQ classes it handles a superpriority class. A physical NMI request, or a virtual INMI or FNMI request, belongs to that class, and the ordinary I and F mask bits do not hold it off. Only a global all-interrupt mask holds superpriority requests off. The same happens on its own when the stack-select bit and the spin-mask enable of the current level are both set.

Each exception level owns a private copy of the control bits, and the current level picks which copy governs delivery. Software writes a copy through a simple write port. An illegal exception return reloads the all-interrupt, I and F bits of the current level's copy from the saved mask value. The unit also presents a pending-status summary for software to read. The delivery decision, the class code and the status are all registered.

Top module: `spm_unit`

## Requirements
- R1: While the all-interrupt bit (control bit 5) of the selected copy is 1, no interrupt of any class is taken, superpriority included.
- R2: While the stack-select bit (control bit 4) and the spin-mask enable (control bit 2) of the selected copy are both 1, no interrupt is taken. Either bit alone masks nothing.
- R3: There is one control copy per exception level, and cur_el selects the copy in use. A write to one level's copy leaves the delivery behaviour of every other level unchanged.
- R4: While the NMI enable (control bit 3) is 0, three requests fall back to ordinary classes, and the ordinary masks then apply to them. A physical NMI becomes a plain IRQ (class 3), a virtual INMI becomes a virtual IRQ (class 7), and a virtual FNMI becomes a virtual FIQ (class 6).
- R5: While the NMI enable is 1 and neither R1 nor R2 masks, a superpriority request is taken even when the I mask (control bit 1) and the F mask (control bit 0) are set.
- R6: When several classes are deliverable, the unit takes the lowest class code. The codes are 1 physical NMI, 2 FIQ, 3 IRQ, 4 virtual FNMI, 5 virtual INMI, 6 virtual FIQ and 7 virtual IRQ. Code 0 goes with take=0.
- R7: The status outputs ignore every mask. st_irq is IRQ, NMI, virtual IRQ or virtual INMI pending. st_fiq is FIQ pending, virtual FIQ pending, or virtual FNMI pending with virt_fiq_en set. st_sirq is the NMI enable and (NMI or virtual INMI). st_sfiq is the NMI enable, virt_fiq_en and virtual FNMI together.
- R8: While virt_fiq_en is 0, a virtual FNMI request is ignored. It is never taken and it affects no status bit.
- R9: On an illegal return, the current level's all-interrupt, I and F bits load from ret_mask[2], ret_mask[1] and ret_mask[0], and its other bits are kept. A software write to that same copy in that same cycle is dropped.
- R10: take, take_cls and the status bits are registered from the requests of the previous cycle. A control write affects the decision made on the edge after the one that stores it.
- R11: Reset clears all outputs. It sets every copy to I and F masked, with the all-interrupt, stack-select, NMI enable and spin-mask bits at 0.
- R12: The I mask blocks IRQ and virtual IRQ, and the F mask blocks FIQ and virtual FIQ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_el | input | LVL_W | Current exception level; selects the control copy |
| wr_en | input | 1 | Write strobe for a control copy |
| wr_lvl | input | LVL_W | Level whose copy is written |
| wr_ctl | input | 6 | New control value {allint, spsel, nmi_en, spin, i, f} |
| ill_ret | input | 1 | Illegal exception return strobe |
| ret_mask | input | 3 | Saved {allint, i, f} reloaded on an illegal return |
| req_irq | input | 1 | Physical IRQ pending |
| req_fiq | input | 1 | Physical FIQ pending |
| req_nmi | input | 1 | Physical NMI pending |
| req_virq | input | 1 | Virtual IRQ pending |
| req_vfiq | input | 1 | Virtual FIQ pending |
| req_vinmi | input | 1 | Virtual INMI pending |
| req_vfnmi | input | 1 | Virtual FNMI pending |
| virt_fiq_en | input | 1 | Hypervisor virtual-FIQ enable |
| take | output | 1 | An interrupt is taken this cycle |
| take_cls | output | 3 | Class code of the taken interrupt |
| st_irq | output | 1 | Status: IRQ-type pending |
| st_fiq | output | 1 | Status: FIQ-type pending |
| st_sirq | output | 1 | Status: superpriority IRQ pending |
| st_sfiq | output | 1 | Status: superpriority FIQ pending |

## Verification
Two faults show up at the ports on the very next cycle: a corrupted control copy, and a wrong choice of copy for the current level. Either one can take an interrupt while the all-interrupt mask is set, or name a fallback class where the superpriority class belongs. A bad priority chain gives a wrong class code when several requests are pending together. A stale or misdirected write only becomes visible after a level switch, so the tests switch levels. An illegal return that overwrites too many fields shows up as an NMI that falls back to IRQ on the following decision.

// File: rtl/spm_pkg.sv
package spm_pkg;

  // Per-level control copy; bit positions match the wr_ctl port.
  typedef struct packed {
    logic allint;     // bit 5
    logic spsel;      // bit 4
    logic nmi_en;     // bit 3
    logic spin_mask;  // bit 2
    logic i_mask;     // bit 1
    logic f_mask;     // bit 0
  } lvl_ctl_t;

  localparam int CTL_W = $bits(lvl_ctl_t);
  localparam lvl_ctl_t CTL_RST = '{allint: 1'b0, spsel: 1'b0, nmi_en: 1'b0,
                                   spin_mask: 1'b0, i_mask: 1'b1, f_mask: 1'b1};

  typedef struct packed {
    logic vf;
    logic vfnmi;
    logic vinmi;
    logic vfiq;
    logic virq;
    logic nmi;
    logic fiq;
    logic irq;
  } req_t;

  // Lower code wins.
  typedef enum logic [2:0] {
    CLS_NONE   = 3'd0,
    CLS_P_NMI  = 3'd1,
    CLS_P_FIQ  = 3'd2,
    CLS_P_IRQ  = 3'd3,
    CLS_V_FNMI = 3'd4,
    CLS_V_INMI = 3'd5,
    CLS_V_FIQ  = 3'd6,
    CLS_V_IRQ  = 3'd7
  } cls_t;

  localparam int NUM_CLS = 8;

  typedef struct packed {
    logic irq;
    logic fiq;
    logic sirq;
    logic sfiq;
  } stat_t;

endpackage

// File: rtl/spm_ctl_bank.sv
module spm_ctl_bank
  import spm_pkg::*;
#(
  parameter int NUM_LVL = 4,
  parameter int LVL_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] cur_el,
  input  logic             wr_en,
  input  logic [LVL_W-1:0] wr_lvl,
  input  lvl_ctl_t         wr_ctl,
  input  logic             ill_ret,
  input  logic [2:0]       ret_mask,
  output lvl_ctl_t         cur_ctl
);

  lvl_ctl_t bank [NUM_LVL];

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    lvl_ctl_t q;
    logic     hit_ret;
    logic     hit_wr;

    assign hit_ret = ill_ret && (int'(cur_el) == g);
    assign hit_wr  = wr_en && (int'(wr_lvl) == g);

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= CTL_RST;
      end else if (hit_ret) begin
        q.allint <= ret_mask[2];
        q.i_mask <= ret_mask[1];
        q.f_mask <= ret_mask[0];
      end else if (hit_wr) begin
        q <= wr_ctl;
      end
    end

    assign bank[g] = q;
  end

  always_comb begin
    cur_ctl = CTL_RST;
    for (int k = 0; k < NUM_LVL; k++) begin
      if (int'(cur_el) == k) cur_ctl = bank[k];
    end
  end

endmodule

// File: rtl/spm_arbiter.sv
module spm_arbiter
  import spm_pkg::*;
(
  input  lvl_ctl_t ctl,
  input  req_t     req,
  output cls_t     cls,
  output stat_t    stat
);

  logic               all_off;
  logic               vfnmi_ok;
  logic [NUM_CLS-1:0] cand;

  always_comb begin
    all_off  = ctl.allint | (ctl.spsel & ctl.spin_mask);
    vfnmi_ok = req.vf & req.vfnmi;

    cand                = '0;
    cand[CLS_P_NMI]     = ctl.nmi_en & req.nmi;
    cand[CLS_P_FIQ]     = req.fiq & ~ctl.f_mask;
    cand[CLS_P_IRQ]     = (req.irq | (~ctl.nmi_en & req.nmi)) & ~ctl.i_mask;
    cand[CLS_V_FNMI]    = ctl.nmi_en & vfnmi_ok;
    cand[CLS_V_INMI]    = ctl.nmi_en & req.vinmi;
    cand[CLS_V_FIQ]     = (req.vfiq | (~ctl.nmi_en & vfnmi_ok)) & ~ctl.f_mask;
    cand[CLS_V_IRQ]     = (req.virq | (~ctl.nmi_en & req.vinmi)) & ~ctl.i_mask;
    if (all_off) cand = '0;

    cls = CLS_NONE;
    for (int k = NUM_CLS - 1; k >= 1; k--) begin
      if (cand[k]) cls = cls_t'(k);
    end

    stat.irq  = req.irq | req.nmi | req.virq | req.vinmi;
    stat.fiq  = req.fiq | req.vfiq | vfnmi_ok;
    stat.sirq = ctl.nmi_en & (req.nmi | req.vinmi);
    stat.sfiq = ctl.nmi_en & vfnmi_ok;
  end

endmodule

// File: rtl/spm_unit.sv
module spm_unit
  import spm_pkg::*;
#(
  parameter  int NUM_LVL = 4,
  localparam int LVL_W   = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] cur_el,
  input  logic             wr_en,
  input  logic [LVL_W-1:0] wr_lvl,
  input  logic [5:0]       wr_ctl,
  input  logic             ill_ret,
  input  logic [2:0]       ret_mask,
  input  logic             req_irq,
  input  logic             req_fiq,
  input  logic             req_nmi,
  input  logic             req_virq,
  input  logic             req_vfiq,
  input  logic             req_vinmi,
  input  logic             req_vfnmi,
  input  logic             virt_fiq_en,
  output logic             take,
  output logic [2:0]       take_cls,
  output logic             st_irq,
  output logic             st_fiq,
  output logic             st_sirq,
  output logic             st_sfiq
);

  lvl_ctl_t cur_ctl;
  req_t     req;
  cls_t     nxt_cls;
  stat_t    nxt_stat;

  assign req = '{vf: virt_fiq_en, vfnmi: req_vfnmi, vinmi: req_vinmi,
                 vfiq: req_vfiq, virq: req_virq, nmi: req_nmi,
                 fiq: req_fiq, irq: req_irq};

  spm_ctl_bank #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .cur_el   (cur_el),
    .wr_en    (wr_en),
    .wr_lvl   (wr_lvl),
    .wr_ctl   (lvl_ctl_t'(wr_ctl)),
    .ill_ret  (ill_ret),
    .ret_mask (ret_mask),
    .cur_ctl  (cur_ctl)
  );

  spm_arbiter u_arb (
    .ctl  (cur_ctl),
    .req  (req),
    .cls  (nxt_cls),
    .stat (nxt_stat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take     <= 1'b0;
      take_cls <= CLS_NONE;
      st_irq   <= 1'b0;
      st_fiq   <= 1'b0;
      st_sirq  <= 1'b0;
      st_sfiq  <= 1'b0;
    end else begin
      take     <= (nxt_cls != CLS_NONE);
      take_cls <= nxt_cls;
      st_irq   <= nxt_stat.irq;
      st_fiq   <= nxt_stat.fiq;
      st_sirq  <= nxt_stat.sirq;
      st_sfiq  <= nxt_stat.sfiq;
    end
  end

endmodule

// File: rtl/spm_unit_chk.sv
module spm_unit_chk
  import spm_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input lvl_ctl_t   cur_ctl,
  input logic       req_irq,
  input logic       req_fiq,
  input logic       req_nmi,
  input logic       req_virq,
  input logic       req_vfiq,
  input logic       req_vinmi,
  input logic       req_vfnmi,
  input logic       virt_fiq_en,
  input logic       take,
  input logic [2:0] take_cls,
  input logic       st_irq,
  input logic       st_fiq
);

  a_r1_allint_holds_off: assert property (@(posedge clk) disable iff (rst)
    cur_ctl.allint |=> !take);

  a_r2_spin_holds_off: assert property (@(posedge clk) disable iff (rst)
    (cur_ctl.spsel && cur_ctl.spin_mask) |=> !take);

  a_r4_no_super_when_off: assert property (@(posedge clk) disable iff (rst)
    !cur_ctl.nmi_en |=> !(take_cls == CLS_P_NMI || take_cls == CLS_V_FNMI ||
                          take_cls == CLS_V_INMI));

  a_r5_nmi_beats_masks: assert property (@(posedge clk) disable iff (rst)
    (cur_ctl.nmi_en && req_nmi && !cur_ctl.allint &&
     !(cur_ctl.spsel && cur_ctl.spin_mask)) |=> (take && take_cls == CLS_P_NMI));

  a_r7_nmi_sets_irq_status: assert property (@(posedge clk) disable iff (rst)
    req_nmi |=> st_irq);

  a_r7_vfnmi_sets_fiq_status: assert property (@(posedge clk) disable iff (rst)
    (req_vfnmi && virt_fiq_en) |=> st_fiq);

  a_r8_vfnmi_gated: assert property (@(posedge clk) disable iff (rst)
    (!virt_fiq_en && req_vfnmi && !req_irq && !req_fiq && !req_nmi &&
     !req_virq && !req_vfiq && !req_vinmi) |=> !take);

  a_r6_code_zero_iff_idle: assert property (@(posedge clk) disable iff (rst)
    !take |-> take_cls == CLS_NONE);

endmodule

bind spm_unit spm_unit_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cur_ctl     (cur_ctl),
  .req_irq     (req_irq),
  .req_fiq     (req_fiq),
  .req_nmi     (req_nmi),
  .req_virq    (req_virq),
  .req_vfiq    (req_vfiq),
  .req_vinmi   (req_vinmi),
  .req_vfnmi   (req_vfnmi),
  .virt_fiq_en (virt_fiq_en),
  .take        (take),
  .take_cls    (take_cls),
  .st_irq      (st_irq),
  .st_fiq      (st_fiq)
);

// File: tb/spm_unit_bench.sv
module spm_unit_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] cur_el;
  logic       wr_en;
  logic [1:0] wr_lvl;
  logic [5:0] wr_ctl;
  logic       ill_ret;
  logic [2:0] ret_mask;
  logic [7:0] reqs;  // {vf, vfnmi, vinmi, vfiq, virq, nmi, fiq, irq}
  logic       take;
  logic [2:0] take_cls;
  logic       st_irq, st_fiq, st_sirq, st_sfiq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  spm_unit #(.NUM_LVL(4)) u_spm_unit (
    .clk(clk), .rst(rst), .cur_el(cur_el), .wr_en(wr_en), .wr_lvl(wr_lvl),
    .wr_ctl(wr_ctl), .ill_ret(ill_ret), .ret_mask(ret_mask),
    .req_irq(reqs[0]), .req_fiq(reqs[1]), .req_nmi(reqs[2]), .req_virq(reqs[3]),
    .req_vfiq(reqs[4]), .req_vinmi(reqs[5]), .req_vfnmi(reqs[6]),
    .virt_fiq_en(reqs[7]),
    .take(take), .take_cls(take_cls), .st_irq(st_irq), .st_fiq(st_fiq),
    .st_sirq(st_sirq), .st_sfiq(st_sfiq)
  );

  // {ctl[5:0], reqs[7:0], take, cls[2:0], status {irq,fiq,sirq,sfiq}}
  localparam int NV = 18;
  localparam logic [21:0] VEC [NV] = '{
    {6'b000000, 8'h01, 1'b1, 3'd3, 4'b1000},  // R6 plain IRQ
    {6'b000010, 8'h01, 1'b0, 3'd0, 4'b1000},  // R12 I mask
    {6'b001010, 8'h04, 1'b1, 3'd1, 4'b1010},  // R5 NMI past I mask
    {6'b101000, 8'h04, 1'b0, 3'd0, 4'b1010},  // R1 allint
    {6'b011100, 8'h04, 1'b0, 3'd0, 4'b1010},  // R2 spsel+spin
    {6'b010000, 8'h01, 1'b1, 3'd3, 4'b1000},  // R2 spsel alone
    {6'b000000, 8'h04, 1'b1, 3'd3, 4'b1000},  // R4 NMI->IRQ
    {6'b000000, 8'h20, 1'b1, 3'd7, 4'b1000},  // R4 VINMI->VIRQ
    {6'b000000, 8'hC0, 1'b1, 3'd6, 4'b0100},  // R4 VFNMI->VFIQ
    {6'b001000, 8'hC0, 1'b1, 3'd4, 4'b0101},  // R7 VFNMI super
    {6'b001000, 8'h40, 1'b0, 3'd0, 4'b0000},  // R8 VF off
    {6'b001000, 8'hFF, 1'b1, 3'd1, 4'b1111},  // R6 all pending
    {6'b000000, 8'h03, 1'b1, 3'd2, 4'b1100},  // R6 FIQ over IRQ
    {6'b000000, 8'h11, 1'b1, 3'd3, 4'b1100},  // R6 physical first
    {6'b000001, 8'h0A, 1'b1, 3'd7, 4'b1100},  // R12 F mask
    {6'b001011, 8'h28, 1'b1, 3'd5, 4'b1010},  // R5 VINMI past masks
    {6'b001000, 8'hE0, 1'b1, 3'd4, 4'b1111},  // R6 FNMI over INMI
    {6'b000011, 8'hC0, 1'b0, 3'd0, 4'b0100}   // R4 fallback masked
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] outs();
    return {take, take_cls, st_irq, st_fiq, st_sirq, st_sfiq};
  endfunction

  task automatic wr(input logic [1:0] lvl, input logic [5:0] v);
    wr_en = 1'b1; wr_lvl = lvl; wr_ctl = v;
    step();
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; cur_el = 2'd2; wr_en = 1'b0; wr_lvl = '0; wr_ctl = '0;
    ill_ret = 1'b0; ret_mask = '0; reqs = 8'h00;
    @(negedge clk);
    step(); step();
    chk("R11 outputs in reset", outs(), 8'h00);
    rst = 1'b0;
    reqs = 8'h05;  // IRQ and NMI on level 2, reset copy
    step(); step();
    chk("R11 reset copy masks IRQ/NMI", outs(), {1'b0, 3'd0, 4'b1000});

    cur_el = 2'd1;
    for (int i = 0; i < NV; i++) begin
      reqs = 8'h00;
      wr(2'd1, VEC[i][21:16]);
      reqs = VEC[i][15:8];
      step();
      chk($sformatf("vector %0d (R1 R2 R4 R5 R6 R7 R8 R12)", i), outs(), VEC[i][7:0]);
    end

    // R10: control write takes effect one decision later
    reqs = 8'h00;
    wr(2'd1, 6'b000000);
    reqs = 8'h01;
    step();
    chk("R10 before write", outs(), {1'b1, 3'd3, 4'b1000});
    wr_en = 1'b1; wr_lvl = 2'd1; wr_ctl = 6'b000010;
    step();
    wr_en = 1'b0;
    chk("R10 edge of write uses old copy", outs(), {1'b1, 3'd3, 4'b1000});
    step();
    chk("R10 next decision uses new copy", outs(), {1'b0, 3'd0, 4'b1000});

    // R3: per-level copies
    wr(2'd1, 6'b000000);
    wr(2'd2, 6'b100000);
    step();
    chk("R3 level1 unaffected by level2 write", outs(), {1'b1, 3'd3, 4'b1000});
    cur_el = 2'd2;
    step();
    chk("R3 level2 allint applies", outs(), {1'b0, 3'd0, 4'b1000});
    cur_el = 2'd3;
    step();
    chk("R3 level3 keeps reset copy", outs(), {1'b0, 3'd0, 4'b1000});
    cur_el = 2'd1;
    step();
    chk("R3 back to level1", outs(), {1'b1, 3'd3, 4'b1000});

    // R9: illegal return reload, wins over same-cycle write
    reqs = 8'h00;
    wr(2'd1, 6'b001000);
    reqs = 8'h04;
    ill_ret = 1'b1; ret_mask = 3'b100;
    wr_en = 1'b1; wr_lvl = 2'd1; wr_ctl = 6'b000000;
    step();
    ill_ret = 1'b0; wr_en = 1'b0;
    step();
    chk("R9 reloaded allint masks NMI", outs(), {1'b0, 3'd0, 4'b1010});
    ill_ret = 1'b1; ret_mask = 3'b000;
    step();
    ill_ret = 1'b0;
    step();
    chk("R9 NMI enable kept, write dropped", outs(), {1'b1, 3'd1, 4'b1010});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule